// File: doc/BRIEF.md
# UART Hex Register Bridge

The bridge gives a host on an asynchronous serial line read and write access to a small register file with 8-bit addresses and 16-bit words. Every value on the line is printable text: the host sends one command letter, the address and data as hexadecimal characters, and a carriage return. For a read, the bridge answers with the word as four hexadecimal characters followed by a carriage return.

The register file holds a 32-bit identifier split over two read-only words, seven read-write words with fixed reset values, and one read-only word that mirrors an input port. Two of the read-write words also drive output ports toward the rest of the chip. Any address outside the map reads as zero and ignores writes. Malformed frames are dropped silently and the parser goes back to waiting for a command letter.

The line format is 8N1. The bit period is `CLKS_PER_BIT` clocks; the default of 868 suits a 100 MHz clock at 115200 baud.

Top module: `hexbrg_top`

## Requirements
- R1: The receiver passes `ser_rx` through a two-flop synchronizer, confirms the start bit at its middle, and samples each of the 8 data bits (LSB first) and the stop bit at mid-bit. A character is accepted only when the stop bit reads high.
- R2: The transmitter idles high and sends each character as one low start bit, 8 data bits LSB first, and one high stop bit. Every bit lasts exactly `CLKS_PER_BIT` clocks, which is well inside 1% of the nominal period.
- R3: A write frame is exactly 8 characters: 'W' (0x57), two address digits, four data digits with the most significant nibble first, and CR (0x0D). On the CR, a read-write target takes the new word, and a later read returns it.
- R4: A read frame is 'R' (0x52), two address digits and CR. The reply is four uppercase hexadecimal characters ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46), most significant nibble first, then CR. A read exchange is 9 characters in total.
- R5: Address and data digits are accepted in either case ('a'-'f' = 0x61-0x66 decode the same as 'A'-'F').
- R6: A frame is discarded with no write and no reply when it has an unknown or lowercase command letter, a non-hex digit, or a character other than CR where CR is due. The parser is then idle and the next 'W' or 'R' starts a new frame.
- R7: Reset values are 0x1212 at 0x02, 0x3434 at 0x03, 0x5656 at 0x04, 0x7878 at 0x05, 0x00F0 at 0x08, 0xDEAD at 0xCC and 0x0001 at 0xEF. All of these are read-write.
- R8: Address 0x00 reads 0x1234 and 0x01 reads 0x5678 (upper and lower halves of `ID_WORD`). Address 0xB1 reads the live value of `ext_status`. Writes to these three addresses are ignored.
- R9: Every other address reads 0x0000, and a write to it changes no register.
- R10: `ctrl_word` always equals the register at 0x08, and `lamp_word` equals the register at 0xEF.
- R11: `rst` is active high and synchronous. While it is high, the registers take their reset values, `ser_tx` is high, and a partly received frame is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_rx | input | 1 | Serial receive line, idles high |
| ser_tx | output | 1 | Serial transmit line, idles high |
| ext_status | input | 16 | Word returned for reads of 0xB1 |
| ctrl_word | output | 16 | Contents of register 0x08 |
| lamp_word | output | 16 | Contents of register 0xEF |

## Verification
The bench reads a sweep of mapped and unmapped addresses, then writes the inverse of each value and reads it back. This catches a design that lets a write through to an identifier, to the status mirror or to an unmapped address, and one that decodes an address into the wrong slot. Frames broken at every stage are sent: an unknown letter, a lowercase letter, a bad digit, and a wrong terminator on both reads and writes. Each must produce no reply and no write; a parser that failed to return to idle would swallow or corrupt the next valid frame. Every reply character is timed from its start-bit edge and sampled at mid-bit, so a transmitter with an off-by-one bit counter, a reversed bit order or lowercase digits shows up at once. A reset in the middle of a frame confirms that the leftover characters are not taken as a command.

// File: rtl/hexbrg_pkg.sv
// Shared constants and helpers for the hex register bridge.
// Assumes 8-bit addresses and 16-bit reset constants; the register table is fixed here.
package hexbrg_pkg;

    localparam logic [7:0] CH_WRITE = 8'h57;   // 'W'
    localparam logic [7:0] CH_READ  = 8'h52;   // 'R'
    localparam logic [7:0] CH_CR    = 8'h0D;

    localparam logic [7:0] ADDR_ID_HI  = 8'h00;
    localparam logic [7:0] ADDR_ID_LO  = 8'h01;
    localparam logic [7:0] ADDR_CTRL   = 8'h08;
    localparam logic [7:0] ADDR_STATUS = 8'hB1;
    localparam logic [7:0] ADDR_LAMP   = 8'hEF;

    localparam int N_RW     = 7;
    localparam int IDX_CTRL = 4;
    localparam int IDX_LAMP = 6;

    typedef struct packed {
        logic       ok;
        logic [3:0] val;
    } hexdig_t;

    // Address of read-write slot i.
    function automatic logic [7:0] rw_addr(input int i);
        case (i)
            0: return 8'h02;
            1: return 8'h03;
            2: return 8'h04;
            3: return 8'h05;
            4: return ADDR_CTRL;
            5: return 8'hCC;
            default: return ADDR_LAMP;
        endcase
    endfunction

    // Reset value of read-write slot i.
    function automatic logic [15:0] rw_init(input int i);
        case (i)
            0: return 16'h1212;
            1: return 16'h3434;
            2: return 16'h5656;
            3: return 16'h7878;
            4: return 16'h00F0;
            5: return 16'hDEAD;
            default: return 16'h0001;
        endcase
    endfunction

    // ASCII character to nibble, either case accepted.
    function automatic hexdig_t hex_decode(input logic [7:0] c);
        hexdig_t d;
        d.ok  = 1'b0;
        d.val = 4'h0;
        if (c >= 8'h30 && c <= 8'h39) begin
            d.ok  = 1'b1;
            d.val = c[3:0];
        end else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) begin
            d.ok  = 1'b1;
            d.val = c[3:0] + 4'd9;
        end
        return d;
    endfunction

    // Nibble to uppercase ASCII character.
    function automatic logic [7:0] hex_encode(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/hexbrg_rx.sv
// Serial receiver, 8N1. Synchronizes the line, confirms the start bit at mid-bit,
// samples data and stop at mid-bit. Assumes CLKS_PER_BIT >= 4.
module hexbrg_rx #(
    parameter int CLKS_PER_BIT = 868
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

    typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_t;

    rx_state_t      st;
    logic           sync1, sync2;
    logic [CW-1:0]  cnt;
    logic [2:0]     bitn;
    logic [7:0]     shreg;

    // Two-flop synchronizer on the incoming line.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_i;
            sync2 <= sync1;
        end
    end

    // Bit timing and character assembly.
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= R_IDLE;
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            case (st)
                R_IDLE: begin
                    cnt <= '0;
                    if (!sync2) st <= R_START;
                end
                R_START: begin
                    if (cnt == HALF) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= sync2 ? R_IDLE : R_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                R_DATA: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {sync2, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= R_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == LAST) begin
                        cnt        <= '0;
                        st         <= R_IDLE;
                        byte_valid <= sync2;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign byte_data = shreg;

endmodule

// File: rtl/hexbrg_tx.sv
// Serial transmitter, 8N1. Takes a byte when idle and go is high; busy rises on
// the same edge so the caller can never issue twice into one frame.
module hexbrg_tx #(
    parameter int CLKS_PER_BIT = 868
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] data_i,
    output logic       busy,
    output logic       line_o
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [9:0]    frame;
    logic [CW-1:0] cnt;
    logic [3:0]    bitn;

    // Frame load and shift-out at one bit per CLKS_PER_BIT clocks.
    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '1;
            cnt   <= '0;
            bitn  <= '0;
            busy  <= 1'b0;
        end else if (!busy) begin
            if (go) begin
                frame <= {1'b1, data_i, 1'b0};
                cnt   <= '0;
                bitn  <= '0;
                busy  <= 1'b1;
            end
        end else if (cnt == LAST) begin
            cnt   <= '0;
            frame <= {1'b1, frame[9:1]};
            if (bitn == 4'd9) busy <= 1'b0;
            else              bitn <= bitn + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign line_o = busy ? frame[0] : 1'b1;

endmodule

// File: rtl/hexbrg_regs.sv
// Register file: two identifier words, a status mirror, N_RW read-write words.
// Read path is combinational on rd_addr; writes take effect on the wr_en cycle.
module hexbrg_regs
    import hexbrg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter logic [2*DATA_W-1:0] ID_WORD = 32'h12345678
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] ext_status,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] lamp_word
);
    logic [N_RW-1:0][DATA_W-1:0] rw_vec;

    for (genvar i = 0; i < N_RW; i++) begin : g_rw
        logic [DATA_W-1:0] q;
        // One read-write slot with its own address match.
        always_ff @(posedge clk) begin
            if (rst)
                q <= DATA_W'(rw_init(i));
            else if (wr_en && wr_addr == ADDR_W'(rw_addr(i)))
                q <= wr_data;
        end
        assign rw_vec[i] = q;
    end

    // Read mux; unmapped addresses give zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_ID_HI))  rd_data = ID_WORD[2*DATA_W-1:DATA_W];
        if (rd_addr == ADDR_W'(ADDR_ID_LO))  rd_data = ID_WORD[DATA_W-1:0];
        if (rd_addr == ADDR_W'(ADDR_STATUS)) rd_data = ext_status;
        for (int i = 0; i < N_RW; i++)
            if (rd_addr == ADDR_W'(rw_addr(i))) rd_data = rw_vec[i];
    end

    assign ctrl_word = rw_vec[IDX_CTRL];
    assign lamp_word = rw_vec[IDX_LAMP];

endmodule

// File: rtl/hexbrg_parser.sv
// Frame parser and reply sequencer. Decodes W/R frames from received characters,
// pulses a write, or captures the read word and streams its hex digits plus CR.
// Characters arriving while a reply is being sent are dropped.
module hexbrg_parser
    import hexbrg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              tx_busy,
    output logic              tx_go,
    output logic [7:0]        tx_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int NADIG = ADDR_W / 4;
    localparam int NDIG  = DATA_W / 4;

    typedef enum logic [2:0] {P_IDLE, P_ADDR, P_DATA, P_TERM, P_REPLY} p_state_t;

    p_state_t          st;
    logic              is_wr;
    logic [3:0]        cnt;
    logic [3:0]        idx;
    logic [DATA_W-1:0] word_q;
    hexdig_t           dig;

    assign dig   = hex_decode(rx_data);
    assign tx_go = (st == P_REPLY) && !tx_busy;

    // Frame state machine.
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= P_IDLE;
            is_wr  <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            addr_q <= '0;
            data_q <= '0;
            word_q <= '0;
            wr_en  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            case (st)
                P_IDLE: if (rx_valid) begin
                    cnt <= '0;
                    if (rx_data == CH_WRITE) begin
                        is_wr <= 1'b1;
                        st    <= P_ADDR;
                    end else if (rx_data == CH_READ) begin
                        is_wr <= 1'b0;
                        st    <= P_ADDR;
                    end
                end
                P_ADDR: if (rx_valid) begin
                    if (!dig.ok) begin
                        st <= P_IDLE;
                    end else begin
                        addr_q <= {addr_q[ADDR_W-5:0], dig.val};
                        cnt    <= cnt + 1'b1;
                        if (cnt == 4'(NADIG - 1)) begin
                            cnt <= '0;
                            st  <= is_wr ? P_DATA : P_TERM;
                        end
                    end
                end
                P_DATA: if (rx_valid) begin
                    if (!dig.ok) begin
                        st <= P_IDLE;
                    end else begin
                        data_q <= {data_q[DATA_W-5:0], dig.val};
                        cnt    <= cnt + 1'b1;
                        if (cnt == 4'(NDIG - 1)) st <= P_TERM;
                    end
                end
                P_TERM: if (rx_valid) begin
                    st <= P_IDLE;
                    if (rx_data == CH_CR) begin
                        if (is_wr) begin
                            wr_en <= 1'b1;
                        end else begin
                            word_q <= rd_data;
                            idx    <= '0;
                            st     <= P_REPLY;
                        end
                    end
                end
                default: if (tx_go) begin
                    if (idx == 4'(NDIG)) st <= P_IDLE;
                    else                 idx <= idx + 1'b1;
                end
            endcase
        end
    end

    // Reply character for the current digit position.
    logic [3:0]        rev;
    logic [DATA_W-1:0] shifted;
    always_comb begin
        rev     = 4'(NDIG - 1) - idx;
        shifted = word_q >> {rev, 2'b00};
        tx_data = (idx < 4'(NDIG)) ? hex_encode(shifted[3:0]) : CH_CR;
    end

endmodule

// File: rtl/hexbrg_top.sv
// Top of the hex register bridge: receiver, parser, register file, transmitter.
// Assumes ADDR_W and DATA_W are multiples of 4 and rst is synchronous.
module hexbrg_top #(
    parameter int CLKS_PER_BIT = 868,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter logic [2*DATA_W-1:0] ID_WORD = 32'h12345678
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_rx,
    output logic              ser_tx,
    input  logic [DATA_W-1:0] ext_status,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] lamp_word
);
    logic              rx_valid;
    logic [7:0]        rx_data;
    logic              tx_go;
    logic [7:0]        tx_data;
    logic              tx_busy;
    logic              wr_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_data;

    hexbrg_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst), .line_i(ser_rx),
        .byte_valid(rx_valid), .byte_data(rx_data)
    );

    hexbrg_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parse (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_busy(tx_busy), .tx_go(tx_go), .tx_data(tx_data),
        .wr_en(wr_en), .addr_q(addr_q), .data_q(data_q), .rd_data(rd_data)
    );

    hexbrg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_WORD(ID_WORD)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr_q), .wr_data(data_q),
        .rd_addr(addr_q), .rd_data(rd_data), .ext_status(ext_status),
        .ctrl_word(ctrl_word), .lamp_word(lamp_word)
    );

    hexbrg_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .go(tx_go), .data_i(tx_data),
        .busy(tx_busy), .line_o(ser_tx)
    );

endmodule

// File: rtl/hexbrg_chk.sv
// Assertion checker for hexbrg_top, attached by bind.
module hexbrg_chk
    import hexbrg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_tx,
    input logic              tx_go,
    input logic              tx_busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr_q,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [DATA_W-1:0] lamp_word
);
    // R2: a character starts with a low start bit right after it is issued.
    a_r2_start_bit: assert property (@(posedge clk) disable iff (rst)
        tx_go |=> !ser_tx);

    // R2: the parser never issues a character into a frame in flight.
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        tx_go |-> !tx_busy);

    // R3: a completed write frame gives a single-cycle write strobe.
    a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R10: the control output changes only through a write to its address.
    a_r10_ctrl_by_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> ($past(wr_en) && $past(addr_q) == ADDR_W'(ADDR_CTRL)));

    // R10: the lamp output changes only through a write to its address.
    a_r10_lamp_by_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(lamp_word) |-> ($past(wr_en) && $past(addr_q) == ADDR_W'(ADDR_LAMP)));

    // R11: the line is idle high whenever no character is being sent.
    a_r11_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> ser_tx);

endmodule

bind hexbrg_top hexbrg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ser_tx(ser_tx), .tx_go(tx_go), .tx_busy(tx_busy),
    .wr_en(wr_en), .addr_q(addr_q), .ctrl_word(ctrl_word), .lamp_word(lamp_word)
);

// File: tb/hexbrg_top_tb_top.sv
module hexbrg_top_tb_top;
    localparam int CPB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_rx = 1'b1;
    logic        ser_tx;
    logic [15:0] ext_status = 16'hA5C3;
    logic [15:0] ctrl_word;
    logic [15:0] lamp_word;

    always #10 clk = ~clk;   // 50 MHz

    hexbrg_top #(.CLKS_PER_BIT(CPB)) dut_i (
        .clk(clk), .rst(rst), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .ext_status(ext_status), .ctrl_word(ctrl_word), .lamp_word(lamp_word)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [7:0]  cap [0:1023];
    int          cap_n = 0;
    logic [15:0] model [0:255];
    bit          rw_map [0:255];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hx(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h57 : 8'h37) + {4'h0, n};
    endfunction

    // Expected register map, built from the requirements.
    task automatic model_reset();
        for (int a = 0; a < 256; a++) begin
            model[a]  = 16'h0000;
            rw_map[a] = 1'b0;
        end
        model[8'h00] = 16'h1234; model[8'h01] = 16'h5678;
        model[8'h02] = 16'h1212; model[8'h03] = 16'h3434;
        model[8'h04] = 16'h5656; model[8'h05] = 16'h7878;
        model[8'h08] = 16'h00F0; model[8'hCC] = 16'hDEAD;
        model[8'hEF] = 16'h0001;
        rw_map[8'h02] = 1'b1; rw_map[8'h03] = 1'b1; rw_map[8'h04] = 1'b1;
        rw_map[8'h05] = 1'b1; rw_map[8'h08] = 1'b1; rw_map[8'hCC] = 1'b1;
        rw_map[8'hEF] = 1'b1;
    endtask

    function automatic logic [15:0] expv(input logic [7:0] a);
        return (a == 8'hB1) ? ext_status : model[a];
    endfunction

    task automatic send_byte(input logic [7:0] b);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ser_rx = fr[i];
            repeat (CPB - 1) @(negedge clk);
        end
    endtask

    task automatic send_write(input logic [7:0] a, input logic [15:0] d, input bit lower);
        send_byte(8'h57);
        send_byte(hx(a[7:4], lower));  send_byte(hx(a[3:0], lower));
        send_byte(hx(d[15:12], lower)); send_byte(hx(d[11:8], lower));
        send_byte(hx(d[7:4], lower));   send_byte(hx(d[3:0], lower));
        send_byte(8'h0D);
        repeat (4) @(negedge clk);
        if (rw_map[a]) model[a] = d;
    endtask

    // R4: read and compare the reply character by character.
    task automatic rd_check(input logic [7:0] a, input bit lower, input string req);
        int base;
        int t;
        logic [15:0] e;
        e = expv(a);
        base = cap_n;
        send_byte(8'h52);
        send_byte(hx(a[7:4], lower));
        send_byte(hx(a[3:0], lower));
        send_byte(8'h0D);
        t = 0;
        while (cap_n < base + 5 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (CPB) @(negedge clk);
        chk(cap_n == base + 5, "R4", "reply length", 32'(cap_n - base), 32'd5);
        for (int k = 0; k < 4; k++)
            chk(cap[base + k] == hx(e[15 - 4*k -: 4], 1'b0), req,
                $sformatf("addr %h digit %0d", a, k), 32'(cap[base + k]),
                32'(hx(e[15 - 4*k -: 4], 1'b0)));
        chk(cap[base + 4] == 8'h0D, "R4", "reply terminator", 32'(cap[base + 4]), 32'h0D);
    endtask

    // R6: a malformed frame must produce no reply at all.
    task automatic no_reply(input string what);
        int base;
        base = cap_n;
        repeat (30 * CPB) @(negedge clk);
        chk(cap_n == base, "R6", what, 32'(cap_n - base), 32'd0);
    endtask

    // Reply monitor: R2 timing of each start run, bit sampling at mid-bit.
    initial begin : cap_proc
        logic [7:0] b;
        logic       stop_v;
        int         rise;
        int         tz;
        forever begin
            @(negedge clk);
            if (!rst && ser_tx === 1'b0) begin
                rise = -1;
                for (int j = 0; j <= 9 * CPB + CPB / 2; j++) begin
                    if (rise < 0 && ser_tx === 1'b1) rise = j;
                    for (int k = 1; k <= 9; k++)
                        if (j == CPB / 2 + k * CPB) begin
                            if (k <= 8) b[k-1] = ser_tx;
                            else        stop_v = ser_tx;
                        end
                    if (j < 9 * CPB + CPB / 2) @(negedge clk);
                end
                tz = 0;
                while (tz < 8 && b[tz] == 1'b0) tz++;
                chk(rise == CPB * (1 + tz), "R2", "start-bit run length",
                    32'(rise), 32'(CPB * (1 + tz)));
                chk(stop_v === 1'b1, "R2", "stop bit high", 32'(stop_v), 32'd1);
                if (cap_n < 1024) cap[cap_n] = b;
                cap_n++;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    int alist [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                       8'h08, 8'h09, 8'hB1, 8'hCC, 8'hEF, 8'hFF, 8'h80, 8'hAB};

    initial begin : stim
        model_reset();
        repeat (5) @(negedge clk);
        // R11: state while reset is held.
        chk(ser_tx === 1'b1, "R11", "tx idle in reset", 32'(ser_tx), 32'd1);
        chk(ctrl_word == 16'h00F0, "R11", "ctrl in reset", 32'(ctrl_word), 32'h00F0);
        chk(lamp_word == 16'h0001, "R11", "lamp in reset", 32'(lamp_word), 32'h0001);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R7 R8 R9 R1: reset values over a sweep of mapped and unmapped addresses.
        foreach (alist[i]) rd_check(8'(alist[i]), 1'b0, "R7");

        // R3 R8 R9: write the inverse everywhere and read it back.
        foreach (alist[i]) begin
            send_write(8'(alist[i]), ~expv(8'(alist[i])), 1'b0);
            rd_check(8'(alist[i]), 1'b0, rw_map[alist[i]] ? "R3" : "R8");
        end
        rd_check(8'h10, 1'b0, "R9");

        // R10: output ports follow their registers.
        send_write(8'h08, 16'h4C2B, 1'b0);
        chk(ctrl_word == 16'h4C2B, "R10", "ctrl follows 0x08", 32'(ctrl_word), 32'h4C2B);
        send_write(8'hEF, 16'h9E07, 1'b0);
        chk(lamp_word == 16'h9E07, "R10", "lamp follows 0xEF", 32'(lamp_word), 32'h9E07);
        chk(ctrl_word == 16'h4C2B, "R10", "ctrl unaffected", 32'(ctrl_word), 32'h4C2B);

        // R5: lowercase digits in address and data.
        send_write(8'hCC, 16'hABCD, 1'b1);
        rd_check(8'hCC, 1'b1, "R5");
        send_write(8'h03, 16'hF0E1, 1'b1);
        rd_check(8'h03, 1'b0, "R5");

        // R8: status mirror follows the input port live.
        ext_status = 16'h0F1E;
        rd_check(8'hB1, 1'b0, "R8");

        // R6: malformed frames.
        send_byte(8'h58); send_byte(8'h30); send_byte(8'h32); send_byte(8'h0D);
        no_reply("unknown letter");
        send_byte(8'h72); send_byte(8'h30); send_byte(8'h32); send_byte(8'h0D);
        no_reply("lowercase letter");
        send_byte(8'h52); send_byte(8'h30); send_byte(8'h32); send_byte(8'h5A);
        no_reply("bad read terminator");
        send_byte(8'h52); send_byte(8'h47); send_byte(8'h32); send_byte(8'h0D);
        no_reply("bad address digit");
        send_byte(8'h57); send_byte(8'h30); send_byte(8'h32);
        send_byte(8'h31); send_byte(8'h32); send_byte(8'h47);
        send_byte(8'h57); send_byte(8'h30); send_byte(8'h32);
        send_byte(8'h31); send_byte(8'h31); send_byte(8'h31); send_byte(8'h31);
        send_byte(8'h5A);
        no_reply("bad write frames");
        rd_check(8'h02, 1'b0, "R6");

        // R11: reset in the middle of a write frame drops it.
        send_write(8'h02, 16'hBEEF, 1'b0);
        send_byte(8'h57); send_byte(8'h30); send_byte(8'h32);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(ctrl_word == 16'h00F0, "R11", "ctrl after reset", 32'(ctrl_word), 32'h00F0);
        rst = 1'b0;
        model_reset();
        send_byte(8'h31); send_byte(8'h31); send_byte(8'h31); send_byte(8'h31);
        send_byte(8'h0D);
        no_reply("frame tail after reset");
        rd_check(8'h02, 1'b0, "R11");
        rd_check(8'h00, 1'b0, "R7");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule